// File: doc/BRIEF.md
# Frame-Rate Management Channel Receiver with Double-Check Acknowledge

This block sits on the receive side of a slow management channel that carries one byte and one transmit-enable flag (E) per frame, and answers on an acknowledge flag (A) that travels back to the sender in the next frames. Both flags are active low: 0 means asserted, 1 means released or idle. The block takes in a byte only after the same value has arrived in two consecutive frames. It drives A low to confirm the byte, and A follows the handshake so that the sender knows when to move on to the next byte.

The sender marks the first copy of every byte after the first by releasing E. The block releases A on that frame and asserts A again when the matching second copy arrives with E low. When E stays released for two frames in a row, the message is closed. The assembled two-byte word is then handed to a register-access client together with a one-cycle valid pulse and one of three decoded indicators: read (a response must be produced), write (carry it out, no response), or invalid (acknowledged on the channel but ignored). All decisions are taken on clock edges where `frame_tick` is high. Between ticks the channel inputs may carry anything.

States: `ST_IDLE` (no message, A released), `ST_FIRST` (first copy of the opening byte held, A released), `ST_ACKED` (a byte accepted, A asserted), `ST_RELEASED` (E released for one frame, A released, candidate held), `ST_MISMATCH` (two differing copies seen, A held asserted). Transitions on a tick: IDLE→FIRST on E low; FIRST→ACKED on a matching copy with E low, FIRST→MISMATCH on a differing copy with E low, FIRST→IDLE on E released; ACKED stays on E low, ACKED→RELEASED on E released; RELEASED→ACKED on a matching copy with E low, RELEASED→MISMATCH on a differing copy with E low, RELEASED→IDLE on E released (message delivered); MISMATCH→ACKED on a matching copy with E low, MISMATCH stays on a differing copy with E low, MISMATCH→RELEASED on E released.

Top module: `mon_rx_top`

## Requirements
- R1: After reset, `mon_a_n` is 1 (released) and `msg_valid` is 0, and they stay so while no frame arrives.
- R2: The opening byte of a message is accepted when two consecutive frames carry it with E low. `mon_a_n` stays 1 after the first copy and goes to 0 after the second copy's tick.
- R3: While the accepted byte keeps repeating with E low, `mon_a_n` stays 0.
- R4: Each later byte starts with a frame that has E released. `mon_a_n` goes to 1 on that frame and returns to 0 when the next frame carries the same byte with E low.
- R5: When a frame with E low carries a byte that differs from the previous frame's byte, `mon_a_n` goes to 0 and stays 0 until two consecutive frames with E low carry the same byte. The later value is then accepted.
- R6: Two consecutive frames with E released after an accepted byte end the message. `msg_valid` is then high for exactly one clock cycle, in the cycle after that tick, and `mon_a_n` is 1 in that cycle.
- R7: For a two-byte message, `msg_word` is {first byte, second byte}. Bits [15:14] equal to 2'b10 set `msg_rd` (response requested), and 2'b01 sets `msg_wr` (no response). Exactly one of `msg_rd`, `msg_wr` and `msg_bad` is high with `msg_valid`.
- R8: A message whose bits [15:14] are 2'b00 or 2'b11, or whose accepted byte count differs from two, is acknowledged with the same A pattern but is delivered with `msg_bad`=1 and `msg_rd`=`msg_wr`=0.
- R9: On cycles without `frame_tick`, the channel inputs have no effect: `mon_a_n` and the message state are unchanged.
- R10: If E is released in the frame right after the first copy of an opening byte, the attempt is dropped. No message is delivered and `mon_a_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | One-cycle strobe marking the sample point of a frame |
| mon_byte | input | 8 | Channel byte of the current frame |
| mon_e_n | input | 1 | Incoming transmit-enable flag, 0 = active |
| mon_a_n | output | 1 | Outgoing acknowledge flag, 0 = active |
| msg_valid | output | 1 | One-cycle pulse: a message has closed |
| msg_word | output | 16 | Assembled message, first byte in the upper half |
| msg_rd | output | 1 | Read command: a response is required |
| msg_wr | output | 1 | Write command: act, no response |
| msg_bad | output | 1 | Invalid message: no action |

## Verification
The receiver is driven with clean messages, where each byte is sent exactly twice, and with stretched messages, where the accepted byte repeats for extra frames. These separate the first-copy release from a stuck acknowledge. Back-to-back bytes with the same value show whether E, and not the data, marks a new byte. Corrupted copies that differ between frames, in the opening byte and in a later byte, exercise the held acknowledge and which value ends up accepted. Messages with one or three bytes, unused command codes, an aborted opening and random data between ticks show that invalid traffic is still acknowledged and that nothing outside the tick is sampled.

// File: rtl/mon_rx_pkg.sv
package mon_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_FIRST    = 3'd1,
        ST_ACKED    = 3'd2,
        ST_RELEASED = 3'd3,
        ST_MISMATCH = 3'd4
    } mon_state_e;

    localparam logic FLAG_ACTIVE   = 1'b0;
    localparam logic FLAG_RELEASED = 1'b1;

endpackage

// File: rtl/mon_pair_check.sv
module mon_pair_check #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    output logic              match,
    output logic [BYTE_W-1:0] held
);

    logic [BYTE_W-1:0] cand_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q <= '1;
        end else if (load) begin
            cand_q <= din;
        end
    end

    always_comb begin
        match = (din == cand_q);
        held  = cand_q;
    end

endmodule

// File: rtl/mon_msg_asm.sv
module mon_msg_asm #(
    parameter int BYTE_W    = 8,
    parameter int MSG_BYTES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        push,
    input  logic [BYTE_W-1:0]           din,
    output logic [BYTE_W*MSG_BYTES-1:0] word,
    output logic                        count_ok
);

    localparam int WORD_W = BYTE_W * MSG_BYTES;
    localparam int CNT_W  = $clog2(MSG_BYTES + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MSG_BYTES);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(MSG_BYTES + 1);

    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  cnt_q;

    generate
        if (MSG_BYTES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (clear) begin
                    word_q <= '0;
                end else if (push) begin
                    word_q <= {word_q[WORD_W-BYTE_W-1:0], din};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (clear) begin
                    word_q <= '0;
                end else if (push) begin
                    word_q <= din;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (push && (cnt_q != CNT_OVER)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        word     = word_q;
        count_ok = (cnt_q == CNT_FULL);
    end

endmodule

// File: rtl/mon_cmd_decode.sv
module mon_cmd_decode #(
    parameter int          WORD_W = 16,
    parameter int          CMD_W  = 2,
    parameter logic [CMD_W-1:0] CMD_RD = 2'b10,
    parameter logic [CMD_W-1:0] CMD_WR = 2'b01
) (
    input  logic [WORD_W-1:0] word,
    input  logic              count_ok,
    output logic              is_rd,
    output logic              is_wr,
    output logic              is_bad
);

    logic [CMD_W-1:0] cmd;

    always_comb begin
        cmd    = word[WORD_W-1 -: CMD_W];
        is_rd  = count_ok && (cmd == CMD_RD);
        is_wr  = count_ok && (cmd == CMD_WR);
        is_bad = !(is_rd || is_wr);
    end

endmodule

// File: rtl/mon_rx_top.sv
module mon_rx_top
    import mon_rx_pkg::*;
#(
    parameter int               BYTE_W    = 8,
    parameter int               MSG_BYTES = 2,
    parameter int               CMD_W     = 2,
    parameter logic [CMD_W-1:0] CMD_RD    = 2'b10,
    parameter logic [CMD_W-1:0] CMD_WR    = 2'b01
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_tick,
    input  logic [BYTE_W-1:0]           mon_byte,
    input  logic                        mon_e_n,
    output logic                        mon_a_n,
    output logic                        msg_valid,
    output logic [BYTE_W*MSG_BYTES-1:0] msg_word,
    output logic                        msg_rd,
    output logic                        msg_wr,
    output logic                        msg_bad
);

    localparam int WORD_W = BYTE_W * MSG_BYTES;

    mon_state_e state_q, state_d;

    logic              e_act;
    logic              same;
    logic [BYTE_W-1:0] cand;
    logic              do_load;
    logic              do_accept;
    logic              do_clear;
    logic              do_deliver;
    logic              a_next;
    logic [WORD_W-1:0] asm_word;
    logic              asm_ok;
    logic              dec_rd;
    logic              dec_wr;
    logic              dec_bad;

    assign e_act = (mon_e_n == FLAG_ACTIVE);

    mon_pair_check #(
        .BYTE_W (BYTE_W)
    ) u_pair (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (do_load),
        .din   (mon_byte),
        .match (same),
        .held  (cand)
    );

    mon_msg_asm #(
        .BYTE_W    (BYTE_W),
        .MSG_BYTES (MSG_BYTES)
    ) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (do_clear),
        .push     (do_accept),
        .din      (cand),
        .word     (asm_word),
        .count_ok (asm_ok)
    );

    mon_cmd_decode #(
        .WORD_W (WORD_W),
        .CMD_W  (CMD_W),
        .CMD_RD (CMD_RD),
        .CMD_WR (CMD_WR)
    ) u_dec (
        .word     (asm_word),
        .count_ok (asm_ok),
        .is_rd    (dec_rd),
        .is_wr    (dec_wr),
        .is_bad   (dec_bad)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and per-frame control
    always_comb begin
        state_d    = state_q;
        do_load    = 1'b0;
        do_accept  = 1'b0;
        do_clear   = 1'b0;
        do_deliver = 1'b0;
        a_next     = mon_a_n;
        if (frame_tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    a_next = FLAG_RELEASED;
                    if (e_act) begin
                        do_load  = 1'b1;
                        do_clear = 1'b1;
                        state_d  = ST_FIRST;
                    end
                end
                ST_FIRST: begin
                    if (!e_act) begin
                        a_next  = FLAG_RELEASED;
                        state_d = ST_IDLE;
                    end else if (same) begin
                        do_accept = 1'b1;
                        a_next    = FLAG_ACTIVE;
                        state_d   = ST_ACKED;
                    end else begin
                        do_load = 1'b1;
                        a_next  = FLAG_ACTIVE;
                        state_d = ST_MISMATCH;
                    end
                end
                ST_ACKED: begin
                    if (!e_act) begin
                        do_load = 1'b1;
                        a_next  = FLAG_RELEASED;
                        state_d = ST_RELEASED;
                    end else begin
                        a_next  = FLAG_ACTIVE;
                    end
                end
                ST_RELEASED: begin
                    if (!e_act) begin
                        do_deliver = 1'b1;
                        a_next     = FLAG_RELEASED;
                        state_d    = ST_IDLE;
                    end else if (same) begin
                        do_accept = 1'b1;
                        a_next    = FLAG_ACTIVE;
                        state_d   = ST_ACKED;
                    end else begin
                        do_load = 1'b1;
                        a_next  = FLAG_ACTIVE;
                        state_d = ST_MISMATCH;
                    end
                end
                ST_MISMATCH: begin
                    if (!e_act) begin
                        do_load = 1'b1;
                        a_next  = FLAG_RELEASED;
                        state_d = ST_RELEASED;
                    end else if (same) begin
                        do_accept = 1'b1;
                        a_next    = FLAG_ACTIVE;
                        state_d   = ST_ACKED;
                    end else begin
                        do_load = 1'b1;
                        a_next  = FLAG_ACTIVE;
                    end
                end
                default: begin
                    a_next  = FLAG_RELEASED;
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_a_n   <= FLAG_RELEASED;
            msg_valid <= 1'b0;
            msg_word  <= '0;
            msg_rd    <= 1'b0;
            msg_wr    <= 1'b0;
            msg_bad   <= 1'b0;
        end else begin
            mon_a_n   <= a_next;
            msg_valid <= do_deliver;
            if (do_deliver) begin
                msg_word <= asm_word;
                msg_rd   <= dec_rd;
                msg_wr   <= dec_wr;
                msg_bad  <= dec_bad;
            end else begin
                msg_rd   <= 1'b0;
                msg_wr   <= 1'b0;
                msg_bad  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mon_rx_checker.sv
module mon_rx_checker (
    input logic clk,
    input logic rst_n,
    input logic frame_tick,
    input logic mon_a_n,
    input logic msg_valid,
    input logic msg_rd,
    input logic msg_wr,
    input logic msg_bad
);

    // R6: delivery pulse is a single cycle
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> !msg_valid);

    // R6: acknowledge is released when the message closes
    a_r6_released_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> mon_a_n);

    // R7: exactly one indicator with each delivery
    a_r7_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ($countones({msg_rd, msg_wr, msg_bad}) == 1));

    // R8: no indicator outside a delivery
    a_r8_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |-> !(msg_rd || msg_wr || msg_bad));

    // R9: nothing moves without a frame strobe
    a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> ($stable(mon_a_n) && !msg_valid));

endmodule

bind mon_rx_top mon_rx_checker u_mon_rx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .mon_a_n    (mon_a_n),
    .msg_valid  (msg_valid),
    .msg_rd     (msg_rd),
    .msg_wr     (msg_wr),
    .msg_bad    (msg_bad)
);

// File: tb/mon_rx_top_bench.sv
module mon_rx_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_tick = 1'b0;
    logic [7:0]  mon_byte = 8'hFF;
    logic        mon_e_n = 1'b1;
    logic        mon_a_n;
    logic        msg_valid;
    logic [15:0] msg_word;
    logic        msg_rd;
    logic        msg_wr;
    logic        msg_bad;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    mon_rx_top u_mon_rx_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .mon_byte   (mon_byte),
        .mon_e_n    (mon_e_n),
        .mon_a_n    (mon_a_n),
        .msg_valid  (msg_valid),
        .msg_word   (msg_word),
        .msg_rd     (msg_rd),
        .msg_wr     (msg_wr),
        .msg_bad    (msg_bad)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // phase: 0 no message, 1 one copy of opening byte, 2 byte taken,
    //        3 E released once, 4 copies disagree
    int        m_phase = 0;
    int        m_prev  = -1;
    bit        m_a     = 1'b1;
    bit        m_valid = 1'b0;
    bit [15:0] m_word  = '0;
    bit        m_rd = 0, m_wr = 0, m_bad = 0;
    byte unsigned m_bytes[$];

    task automatic m_close();
        m_valid = 1'b1;
        m_rd = 0; m_wr = 0; m_bad = 1;
        if (m_bytes.size() == 2) begin
            m_word = {m_bytes[0], m_bytes[1]};
            m_rd   = (m_word[15:14] == 2'b10);
            m_wr   = (m_word[15:14] == 2'b01);
            m_bad  = !(m_rd || m_wr);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_a = 1; m_valid = 0; m_prev = -1;
            m_bytes.delete();
        end else begin
            m_valid = 1'b0;
            if (frame_tick) begin
                bit e_low;
                int b;
                e_low = (mon_e_n == 1'b0);
                b = int'(mon_byte);
                if (m_phase == 0) begin
                    m_a = 1;
                    if (e_low) begin
                        m_bytes.delete();
                        m_prev = b; m_phase = 1;
                    end
                end else if (!e_low) begin
                    if (m_phase == 1) begin
                        m_phase = 0; m_a = 1;
                    end else if (m_phase == 3) begin
                        m_close(); m_phase = 0; m_a = 1;
                    end else begin
                        m_prev = b; m_phase = 3; m_a = 1;
                    end
                end else if (m_phase == 2) begin
                    m_a = 0;
                end else if (b == m_prev) begin
                    m_bytes.push_back(byte'(b));
                    m_phase = 2; m_a = 0;
                end else begin
                    m_prev = b; m_phase = 4; m_a = 0;
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(mon_a_n == m_a, "R4 model acknowledge", mon_a_n, m_a);
            check(msg_valid == m_valid, "R6 model delivery", msg_valid, m_valid);
            if (m_valid && msg_valid) begin
                check({msg_rd, msg_wr, msg_bad} == {m_rd, m_wr, m_bad},
                      "R8 model kind", {msg_rd, msg_wr, msg_bad}, {m_rd, m_wr, m_bad});
                if (!m_bad)
                    check(msg_word == m_word, "R7 model word", msg_word, m_word);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic frame(input bit e_n, input logic [7:0] b);
        @(negedge clk);
        mon_e_n = e_n; mon_byte = b; frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        mon_e_n = 1'($urandom);
        mon_byte = 8'($urandom);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mon_e_n = 1'($urandom);
            mon_byte = 8'($urandom);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mon_a_n == 1, "R1 reset acknowledge", mon_a_n, 1);
        check(msg_valid == 0, "R1 reset valid", msg_valid, 0);
        gap(4);
        check(mon_a_n == 1, "R1 idle acknowledge", mon_a_n, 1);

        // read command 85 3C
        frame(0, 8'h85); check(mon_a_n == 1, "R2 first copy released", mon_a_n, 1);
        frame(0, 8'h85); check(mon_a_n == 0, "R2 second copy acked", mon_a_n, 0);
        gap(3);          check(mon_a_n == 0, "R9 held between ticks", mon_a_n, 0);
        frame(0, 8'h85); check(mon_a_n == 0, "R3 repeat stays acked", mon_a_n, 0);
        frame(1, 8'h3C); check(mon_a_n == 1, "R4 new byte releases", mon_a_n, 1);
        frame(0, 8'h3C); check(mon_a_n == 0, "R4 new byte acked", mon_a_n, 0);
        frame(1, 8'hFF); check(msg_valid == 0, "R6 one released frame", msg_valid, 0);
        frame(1, 8'hFF);
        check(msg_valid == 1, "R6 close pulse", msg_valid, 1);
        check(mon_a_n == 1, "R6 idle after close", mon_a_n, 1);
        check(msg_word == 16'h853C, "R7 read word", msg_word, 16'h853C);
        check(msg_rd == 1 && msg_wr == 0, "R7 read kind", msg_rd, 1);
        @(negedge clk);
        check(msg_valid == 0, "R6 pulse one cycle", msg_valid, 0);

        // write command with equal bytes 42 42
        frame(0, 8'h42); frame(0, 8'h42);
        frame(1, 8'h42); check(mon_a_n == 1, "R4 equal value new byte", mon_a_n, 1);
        frame(0, 8'h42); check(mon_a_n == 0, "R4 equal value acked", mon_a_n, 0);
        frame(1, 8'h00); frame(1, 8'h00);
        check(msg_valid == 1 && msg_wr == 1 && msg_rd == 0, "R7 write kind", msg_wr, 1);
        check(msg_word == 16'h4242, "R7 write word", msg_word, 16'h4242);

        // disagreeing copies
        frame(0, 8'h90); check(mon_a_n == 1, "R5 first copy", mon_a_n, 1);
        frame(0, 8'h91); check(mon_a_n == 0, "R5 differing copy asserts", mon_a_n, 0);
        frame(0, 8'h92); check(mon_a_n == 0, "R5 still differing", mon_a_n, 0);
        frame(0, 8'h92); check(mon_a_n == 0, "R5 pair accepted", mon_a_n, 0);
        frame(1, 8'h10); check(mon_a_n == 1, "R4 release", mon_a_n, 1);
        frame(0, 8'h11); check(mon_a_n == 0, "R5 later byte differs", mon_a_n, 0);
        frame(0, 8'h11);
        frame(1, 8'h00); frame(1, 8'h00);
        check(msg_word == 16'h9211, "R5 later value kept", msg_word, 16'h9211);
        check(msg_rd == 1, "R7 read after mismatch", msg_rd, 1);

        // unused command code
        frame(0, 8'hC0); frame(0, 8'hC0);
        check(mon_a_n == 0, "R8 invalid still acked", mon_a_n, 0);
        frame(1, 8'h01); frame(0, 8'h01);
        frame(1, 8'h00); frame(1, 8'h00);
        check(msg_bad == 1 && msg_rd == 0 && msg_wr == 0, "R8 bad code", msg_bad, 1);

        // one-byte message
        frame(0, 8'h81); frame(0, 8'h81);
        frame(1, 8'h00); frame(1, 8'h00);
        check(msg_bad == 1 && msg_rd == 0, "R8 short message", msg_bad, 1);

        // three-byte message
        frame(0, 8'h81); frame(0, 8'h81);
        frame(1, 8'h02); frame(0, 8'h02);
        frame(1, 8'h03); frame(0, 8'h03);
        frame(1, 8'h00); frame(1, 8'h00);
        check(msg_bad == 1 && msg_rd == 0, "R8 long message", msg_bad, 1);

        // aborted opening
        frame(0, 8'h55); frame(1, 8'h55);
        check(mon_a_n == 1, "R10 abort released", mon_a_n, 1);
        frame(1, 8'h55);
        check(msg_valid == 0, "R10 no delivery", msg_valid, 0);
        frame(1, 8'hFF);
        check(msg_valid == 0 && mon_a_n == 1, "R10 stays idle", msg_valid, 0);

        // random traffic against the model
        for (int m = 0; m < 60; m++) begin
            int nb;
            nb = ($urandom % 8 == 0) ? 1 + ($urandom % 3) : 2;
            for (int i = 0; i < nb; i++) begin
                logic [7:0] b;
                b = 8'($urandom);
                frame(i == 0 ? 1'b0 : 1'b1, b);
                if ($urandom % 4 == 0) begin
                    frame(0, b ^ 8'h01);
                    frame(0, b);
                end
                frame(0, b);
                for (int r = 0; r < int'($urandom % 3); r++) frame(0, b);
                gap($urandom % 3);
            end
            frame(1, 8'($urandom));
            gap($urandom % 2);
            frame(1, 8'($urandom));
            gap(1 + $urandom % 3);
        end

        gap(4);
        finish_run();
    end

endmodule